// File: doc/BRIEF.md
# Integer ALU with Priority-Encoded Operation Select

This combinational unit sits in the execute path of a single-cycle 32-bit integer core. The main instruction decoder supplies a two-bit operation class. The instruction supplies its minor opcode field (funct3), bit 5 of funct7 and bit 5 of the major opcode. From these, a small decoder raises one detect line per operation. A priority encoder turns the detect lines into a three-bit operation code, and that code steers the arithmetic/logic datapath.

The datapath adds, subtracts, ANDs, ORs, XORs and does a signed less-than comparison of two operands. It also reports whether the result is all zeros, which the branch logic uses for equality branches. The operation code is exposed as an output so that neighbouring logic and test can observe the selection.

Top module: `alu_unit`

## Requirements
- R1: With operation class 2'b00 (memory address), the code is 3'b000 and the result is src_a + src_b modulo 2^32.
- R2: With operation class 2'b01 (compare-branch), the code is 3'b001 and the result is src_a − src_b modulo 2^32.
- R3: With class 2'b10 and funct3 3'b000, the code is 3'b001 (subtract) only when funct7 bit 5 and opcode bit 5 are both 1. Otherwise it is 3'b000 (add).
- R4: With class 2'b10, funct3 3'b111 gives code 3'b010 with result src_a & src_b. Funct3 3'b110 gives code 3'b011 with result src_a | src_b.
- R5: With class 2'b10 and funct3 3'b100, the code is 3'b100 and the result is src_a ^ src_b.
- R6: With class 2'b10 and funct3 3'b010, the code is 3'b101. The result is 1 when src_a < src_b as two's-complement values, and 0 otherwise.
- R7: Class 2'b11, and class 2'b10 with funct3 of 3'b001, 3'b011 or 3'b101, raise no detect line. These fall back to code 3'b000 (add). Codes 3'b110 and 3'b111 never appear on the code output.
- R8: zero is 1 exactly when all 32 result bits are 0.
- R9: funct7 bit 5 and opcode bit 5 have no effect on the code or the result except under R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 2 | Operation class from the main decoder |
| funct3 | input | 3 | Minor opcode field of the instruction |
| funct7_b5 | input | 1 | Bit 5 of the funct7 field |
| opcode_b5 | input | 1 | Bit 5 of the major opcode (register vs immediate form) |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| op_code | output | 3 | Selected operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Operation selection and the zero flag are resolved together in every evaluation. A subtract with equal operands must give both code 3'b001 and zero high. An XOR of equal operands must give code 3'b100 and zero high. An add that wraps to zero must also raise zero. The bench provokes each case with a table entry and judges the code, the result and the flag together against a model written from the requirements. A randomized sweep then repeats this judgement across every class and funct3 pairing.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'b000,
        ALU_SUB  = 3'b001,
        ALU_AND  = 3'b010,
        ALU_OR   = 3'b011,
        ALU_XOR  = 3'b100,
        ALU_SLT  = 3'b101,
        ALU_RSV6 = 3'b110,
        ALU_RSV7 = 3'b111
    } alu_code_e;

    typedef enum logic [1:0] {
        AOP_MEM = 2'b00,
        AOP_BR  = 2'b01,
        AOP_REG = 2'b10,
        AOP_RSV = 2'b11
    } alu_class_e;

    localparam int unsigned CODE_W  = 3;
    localparam int unsigned N_CODES = 1 << CODE_W;

    function automatic logic signed_lt(input logic [31:0] a, input logic [31:0] b);
        return $signed(a) < $signed(b);
    endfunction

endpackage

// File: rtl/alu_prio_enc.sv
module alu_prio_enc #(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
    import alu_pkg::*;
(
    input  logic [1:0]        alu_op,
    input  logic [2:0]        funct3,
    input  logic              funct7_b5,
    input  logic              opcode_b5,
    output logic [CODE_W-1:0] op_code
);
    logic [N_CODES-1:0] det;
    logic               is_reg;

    always_comb begin
        is_reg              = (alu_op == AOP_REG);
        det                 = '0;
        det[ALU_ADD]        = (alu_op == AOP_MEM) ||
                              (is_reg && funct3 == 3'b000 && !(funct7_b5 && opcode_b5));
        det[ALU_SUB]        = (alu_op == AOP_BR) ||
                              (is_reg && funct3 == 3'b000 && funct7_b5 && opcode_b5);
        det[ALU_AND]        = is_reg && funct3 == 3'b111;
        det[ALU_OR]         = is_reg && funct3 == 3'b110;
        det[ALU_XOR]        = is_reg && funct3 == 3'b100;
        det[ALU_SLT]        = is_reg && funct3 == 3'b010;
    end

    alu_prio_enc #(.N(N_CODES)) u_enc (
        .req (det),
        .idx (op_code)
    );

    always_comb begin
        p_mem_add_r1: assert (alu_op != AOP_MEM || op_code == ALU_ADD)
            else $error("class 00 did not select add");
        p_branch_sub_r2: assert (alu_op != AOP_BR || op_code == ALU_SUB)
            else $error("class 01 did not select sub");
        p_xor_sel_r5: assert (!(is_reg && funct3 == 3'b100) || op_code == ALU_XOR)
            else $error("xor match did not select code 100");
        p_code_legal_r7: assert (op_code != ALU_RSV6 && op_code != ALU_RSV7)
            else $error("reserved code selected");
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [CODE_W-1:0] op_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic              zero
);
    logic lt;

    always_comb begin
        lt = $signed(src_a) < $signed(src_b);
        unique case (alu_code_e'(op_code))
            ALU_ADD:  result = src_a + src_b;
            ALU_SUB:  result = src_a - src_b;
            ALU_AND:  result = src_a & src_b;
            ALU_OR:   result = src_a | src_b;
            ALU_XOR:  result = src_a ^ src_b;
            ALU_SLT:  result = DATA_W'(lt);
            default:  result = '0;
        endcase
        zero = ~|result;
    end

    always_comb begin
        p_slt_bool_r6: assert (op_code != ALU_SLT || result[DATA_W-1:1] == '0)
            else $error("slt result wider than one bit");
    end
endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        alu_op,
    input  logic [2:0]        funct3,
    input  logic              funct7_b5,
    input  logic              opcode_b5,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [2:0]        op_code,
    output logic [DATA_W-1:0] result,
    output logic              zero
);
    logic [CODE_W-1:0] code_w;

    alu_ctrl_dec u_dec (
        .alu_op    (alu_op),
        .funct3    (funct3),
        .funct7_b5 (funct7_b5),
        .opcode_b5 (opcode_b5),
        .op_code   (code_w)
    );

    alu_core #(.DATA_W(DATA_W)) u_core (
        .op_code (code_w),
        .src_a   (src_a),
        .src_b   (src_b),
        .result  (result),
        .zero    (zero)
    );

    assign op_code = code_w;

    always_comb begin
        p_sub_eq_zero_r8: assert (!(code_w == ALU_SUB && src_a == src_b) || zero)
            else $error("equal operands under subtract did not raise zero");
    end
endmodule

// File: tb/alu_unit_bench.sv
module alu_unit_bench;
    logic        clk = 1'b0;
    logic [1:0]  alu_op = '0;
    logic [2:0]  funct3 = '0;
    logic        funct7_b5 = 1'b0;
    logic        opcode_b5 = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [2:0]  op_code;
    logic [31:0] result;
    logic        zero;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    alu_unit u_alu_unit (
        .alu_op(alu_op), .funct3(funct3), .funct7_b5(funct7_b5), .opcode_b5(opcode_b5),
        .src_a(src_a), .src_b(src_b), .op_code(op_code), .result(result), .zero(zero)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  f3;
        logic        f7;
        logic        o5;
        logic [31:0] a;
        logic [31:0] b;
        logic [2:0]  code;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{2'b00, 3'b010, 1'b1, 1'b1, 32'h0000_0010, 32'h0000_0004, 3'b000}, // R1 R9
        '{2'b00, 3'b000, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 3'b000}, // R1 R8 wrap
        '{2'b01, 3'b000, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0005, 3'b001}, // R2 R8
        '{2'b01, 3'b111, 1'b1, 1'b1, 32'h0000_0003, 32'h0000_0007, 3'b001}, // R2 R9
        '{2'b10, 3'b000, 1'b1, 1'b1, 32'h0000_0009, 32'h0000_0004, 3'b001}, // R3
        '{2'b10, 3'b000, 1'b1, 1'b0, 32'h0000_0009, 32'h0000_0004, 3'b000}, // R3
        '{2'b10, 3'b000, 1'b0, 1'b1, 32'h0000_0009, 32'h0000_0004, 3'b000}, // R3
        '{2'b10, 3'b111, 1'b0, 1'b1, 32'hF0F0_F0F0, 32'hFF00_FF00, 3'b010}, // R4
        '{2'b10, 3'b110, 1'b0, 1'b1, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b011}, // R4
        '{2'b10, 3'b100, 1'b0, 1'b1, 32'hAAAA_5555, 32'hAAAA_5555, 3'b100}, // R5 R8
        '{2'b10, 3'b100, 1'b1, 1'b1, 32'h1234_5678, 32'hFFFF_FFFF, 3'b100}, // R5 R9
        '{2'b10, 3'b010, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 3'b101}, // R6
        '{2'b10, 3'b010, 1'b0, 1'b1, 32'h0000_0001, 32'hFFFF_FFFF, 3'b101}, // R6
        '{2'b10, 3'b010, 1'b1, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 3'b101}, // R6
        '{2'b11, 3'b100, 1'b1, 1'b1, 32'h0000_0002, 32'h0000_0003, 3'b000}, // R7
        '{2'b10, 3'b001, 1'b0, 1'b1, 32'h0000_0002, 32'h0000_0003, 3'b000}, // R7
        '{2'b10, 3'b101, 1'b1, 1'b1, 32'h0000_0002, 32'h0000_0003, 3'b000}, // R7
        '{2'b10, 3'b011, 1'b0, 1'b0, 32'h0000_0007, 32'h0000_0008, 3'b000}  // R7
    };

    function automatic logic [2:0] ref_code(input logic [1:0] op, input logic [2:0] f3,
                                            input logic f7, input logic o5);
        if (op == 2'b00) return 3'b000;
        if (op == 2'b01) return 3'b001;
        if (op == 2'b11) return 3'b000;
        case (f3)
            3'b000:  return (f7 && o5) ? 3'b001 : 3'b000;
            3'b111:  return 3'b010;
            3'b110:  return 3'b011;
            3'b100:  return 3'b100;
            3'b010:  return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [31:0] ref_res(input logic [2:0] c, input logic [31:0] a,
                                            input logic [31:0] b);
        case (c)
            3'b000:  return a + b;
            3'b001:  return a - b;
            3'b010:  return a & b;
            3'b011:  return a | b;
            3'b100:  return a ^ b;
            3'b101:  return {31'd0, $signed(a) < $signed(b)};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply_and_check(input string req, input logic [1:0] op, input logic [2:0] f3,
                                   input logic f7, input logic o5, input logic [31:0] a,
                                   input logic [31:0] b, input logic [2:0] exp_code);
        logic [31:0] er;
        @(posedge clk);
        alu_op = op; funct3 = f3; funct7_b5 = f7; opcode_b5 = o5; src_a = a; src_b = b;
        @(negedge clk);
        er = ref_res(exp_code, a, b);
        check({req, " code"}, {29'd0, op_code}, {29'd0, exp_code});
        check({req, " result"}, result, er);
        check("R8 zero", {31'd0, zero}, {31'd0, er == 32'd0});
    endtask

    initial begin
        // Idle inputs: all zero selects add of zeros (R1, R8)
        @(negedge clk);
        check("R1 idle code", {29'd0, op_code}, 32'd0);
        check("R1 idle result", result, 32'd0);
        check("R8 idle zero", {31'd0, zero}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            apply_and_check($sformatf("table[%0d]", i), TBL[i].op, TBL[i].f3, TBL[i].f7,
                            TBL[i].o5, TBL[i].a, TBL[i].b, TBL[i].code);
        end

        // Directed corners
        apply_and_check("R6 equal", 2'b10, 3'b010, 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, 3'b101);
        apply_and_check("R2 min minus one", 2'b01, 3'b000, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_0001, 3'b001);
        apply_and_check("R4 and zero", 2'b10, 3'b111, 1'b1, 1'b0, 32'hAAAA_AAAA, 32'h5555_5555, 3'b010);

        // Randomized sweep over every class/funct3 pairing (R1-related codes via model)
        for (int k = 0; k < 400; k++) begin
            logic [1:0]  op;
            logic [2:0]  f3;
            logic        f7, o5;
            logic [31:0] a, b;
            op = 2'($urandom); f3 = 3'($urandom); f7 = 1'($urandom); o5 = 1'($urandom);
            a = $urandom; b = (k % 8 == 0) ? a : $urandom;
            apply_and_check("R9 sweep", op, f3, f7, o5, a, b, ref_code(op, f3, f7, o5));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule